// File: doc/BRIEF.md
# Virtual PE Schedule Control Register

This block is one 64-bit control and status register inside an interrupt redistributor. Software uses it to place a virtual processing element (vPE) on the physical core and to take it off again. Setting the valid bit starts a parse of the vPE's pending table. Clearing the valid bit starts a deschedule.

A deschedule records whether any enabled interrupt was still pending for the vPE that is leaving. It can also raise a one-cycle default doorbell request. A read-only busy flag reports progress. While valid is 1, busy means the table parse has not finished. While valid is 0, busy means a deschedule is still running.

The table walk and the deschedule work are done by neighbouring logic. That logic is started by one-cycle pulses from this block and answers through done inputs.

Top module: `vpe_sched_reg`

## Requirements
- R1: After reset, the register reads as all zeros and the three outputs parse_start, desched_start and doorbell_req are low.
- R2: The register is reached only at address REG_OFFSET (default 0x78). The bit layout is:
  - bit 63: valid
  - bit 62: doorbell
  - bit 61: pending-last
  - bit 60: busy
  - bit 59: group-0 enable
  - bit 58: group-1 enable
  - bits 57:16: read as 0
  - bits 15:0: vPE id

  A write to any other address changes nothing. A read of any other address returns 0.
- R3: A write with bit 63 = 1 while valid = 0 and busy = 0 is a schedule. On the next cycle valid = 1, busy = 1 and pending-last = 1. It also stores the group enables and the id from the write, and pulses parse_start for exactly one cycle.
- R4: While valid = 1 and busy = 1, a high parse_done clears busy from the next cycle on. parse_done has no effect while busy = 0.
- R5: A write with bit 63 = 0 while valid = 1 and busy = 0 is a deschedule. On the next cycle valid = 0 and busy = 1, and desched_start pulses for exactly one cycle. Pending-last takes the value of irq_pending as sampled in the write cycle.
- R6: A deschedule raises doorbell_req for exactly one cycle, in the same cycle as desched_start, only under three conditions:
  - the write has bit 62 = 1;
  - the write has bit 61 = 0;
  - irq_pending is 0.
- R7: While valid = 0 and busy = 1, a high desched_done clears busy from the next cycle on.
- R8: A write that would change valid while busy = 1 is ignored. No field changes and no pulse is raised. This holds also when the matching done input arrives in the same cycle.
- R9: While valid = 1, the doorbell bit reads as 0. A write with bit 63 = 1 while valid = 1 changes nothing.
- R10: A write with bit 63 = 0 while valid = 0 updates the doorbell bit, both group enables and the id. It raises no pulse and leaves busy and pending-last unchanged.
- R11: Id bits at and above parameter ID_W (default 16) are stored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register-bus byte address |
| bus_wdata | input | 64 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 64 | Read data for bus_addr (combinational) |
| irq_pending | input | 1 | An enabled interrupt is pending for the scheduled vPE |
| parse_done | input | 1 | Pending-table parse has finished |
| desched_done | input | 1 | Deschedule work has finished |
| parse_start | output | 1 | One-cycle request to parse the pending table |
| desched_start | output | 1 | One-cycle request to start a deschedule |
| doorbell_req | output | 1 | One-cycle default doorbell request |

## Verification
The risky overlap is a valid-changing write that lands in the same cycle as the done handshake that ends busy. That write must still be refused, even though busy is low from the next cycle on.

The bench provokes this overlap for both the parse and the deschedule phase. In each case it checks four things on the following cycle:
- busy has cleared;
- valid kept its old value;
- no start pulse appeared;
- a retried write then succeeds.

A second overlap is a deschedule write that coincides with a pending interrupt. Here pending-last and the doorbell decision must both come from the same sampled cycle. The bench sweeps all eight combinations of doorbell bit, pending-last bit and irq_pending to check this.

// File: rtl/vpe_sched_pkg.sv
package vpe_sched_pkg;

    localparam int REG_W      = 64;
    localparam int ID_FIELD_W = 16;

    localparam int BIT_VALID  = 63;
    localparam int BIT_DB     = 62;
    localparam int BIT_PLAST  = 61;
    localparam int BIT_BUSY   = 60;
    localparam int BIT_G0     = 59;
    localparam int BIT_G1     = 58;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_FIELDS,
        CMD_SCHED,
        CMD_DESCHED
    } vpe_cmd_e;

    typedef struct packed {
        logic                  doorbell;
        logic                  grp0_en;
        logic                  grp1_en;
        logic [ID_FIELD_W-1:0] vpe_id;
    } vpe_cfg_t;

    typedef struct packed {
        logic valid;
        logic busy;
        logic pend_last;
    } vpe_stat_t;

    function automatic vpe_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
        vpe_cfg_t c;
        c.doorbell = w[BIT_DB];
        c.grp0_en  = w[BIT_G0];
        c.grp1_en  = w[BIT_G1];
        c.vpe_id   = w[ID_FIELD_W-1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] view_word(input vpe_stat_t s, input vpe_cfg_t c);
        logic [REG_W-1:0] r;
        r                   = '0;
        r[BIT_VALID]        = s.valid;
        r[BIT_DB]           = c.doorbell & ~s.valid;
        r[BIT_PLAST]        = s.pend_last;
        r[BIT_BUSY]         = s.busy;
        r[BIT_G0]           = c.grp0_en;
        r[BIT_G1]           = c.grp1_en;
        r[ID_FIELD_W-1:0]   = c.vpe_id;
        return r;
    endfunction

endpackage

// File: rtl/vpe_sched_decode.sv
module vpe_sched_decode
    import vpe_sched_pkg::*;
(
    input  logic     wr_hit,
    input  logic     wr_valid_bit,
    input  logic     valid_q,
    input  logic     busy_q,
    output vpe_cmd_e cmd
);
    always_comb begin
        cmd = CMD_NONE;
        if (wr_hit) begin
            if (wr_valid_bit != valid_q) begin
                if (!busy_q) cmd = wr_valid_bit ? CMD_SCHED : CMD_DESCHED;
            end else if (!valid_q) begin
                cmd = CMD_FIELDS;
            end
        end
    end
endmodule

// File: rtl/vpe_sched_track.sv
module vpe_sched_track
    import vpe_sched_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  vpe_cmd_e  cmd,
    input  logic      wr_db_bit,
    input  logic      wr_pl_bit,
    input  logic      irq_pending,
    input  logic      parse_done,
    input  logic      desched_done,
    output vpe_stat_t stat,
    output logic      parse_start,
    output logic      desched_start,
    output logic      doorbell_req
);
    logic done_seen;
    assign done_seen = stat.busy && (stat.valid ? parse_done : desched_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat          <= '0;
            parse_start   <= 1'b0;
            desched_start <= 1'b0;
            doorbell_req  <= 1'b0;
        end else begin
            parse_start   <= 1'b0;
            desched_start <= 1'b0;
            doorbell_req  <= 1'b0;
            unique case (cmd)
                CMD_SCHED: begin
                    stat.valid     <= 1'b1;
                    stat.busy      <= 1'b1;
                    stat.pend_last <= 1'b1;
                    parse_start    <= 1'b1;
                end
                CMD_DESCHED: begin
                    stat.valid     <= 1'b0;
                    stat.busy      <= 1'b1;
                    stat.pend_last <= irq_pending;
                    desched_start  <= 1'b1;
                    doorbell_req   <= wr_db_bit & ~wr_pl_bit & ~irq_pending;
                end
                default: begin
                    if (done_seen) stat.busy <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/vpe_sched_fields.sv
module vpe_sched_fields
    import vpe_sched_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  vpe_cmd_e cmd,
    input  vpe_cfg_t wr_cfg,
    output vpe_cfg_t cfg
);
    logic [ID_FIELD_W-1:0] id_trim;

    generate
        if (ID_W < ID_FIELD_W) begin : g_trim
            logic unused_hi;
            assign unused_hi = ^wr_cfg.vpe_id[ID_FIELD_W-1:ID_W];
            assign id_trim   = {{(ID_FIELD_W-ID_W){1'b0}}, wr_cfg.vpe_id[ID_W-1:0]};
        end else begin : g_full
            assign id_trim = wr_cfg.vpe_id;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            case (cmd)
                CMD_FIELDS: begin
                    cfg.doorbell <= wr_cfg.doorbell;
                    cfg.grp0_en  <= wr_cfg.grp0_en;
                    cfg.grp1_en  <= wr_cfg.grp1_en;
                    cfg.vpe_id   <= id_trim;
                end
                CMD_SCHED: begin
                    cfg.grp0_en  <= wr_cfg.grp0_en;
                    cfg.grp1_en  <= wr_cfg.grp1_en;
                    cfg.vpe_id   <= id_trim;
                end
                CMD_DESCHED: cfg.doorbell <= wr_cfg.doorbell;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vpe_sched_reg.sv
module vpe_sched_reg
    import vpe_sched_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h78,
    parameter int              ID_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    input  logic              bus_wr,
    output logic [63:0]       bus_rdata,
    input  logic              irq_pending,
    input  logic              parse_done,
    input  logic              desched_done,
    output logic              parse_start,
    output logic              desched_start,
    output logic              doorbell_req
);
    logic      addr_hit;
    logic      wr_hit;
    vpe_cmd_e  cmd;
    vpe_stat_t stat;
    vpe_cfg_t  cfg;
    logic      unused_wbits;

    assign addr_hit     = (bus_addr == REG_OFFSET);
    assign wr_hit       = addr_hit && bus_wr;
    assign unused_wbits = ^bus_wdata[57:ID_FIELD_W];

    vpe_sched_decode u_dec (
        .wr_hit       (wr_hit),
        .wr_valid_bit (bus_wdata[BIT_VALID]),
        .valid_q      (stat.valid),
        .busy_q       (stat.busy),
        .cmd          (cmd)
    );

    vpe_sched_track u_trk (
        .clk           (clk),
        .rst           (rst),
        .cmd           (cmd),
        .wr_db_bit     (bus_wdata[BIT_DB]),
        .wr_pl_bit     (bus_wdata[BIT_PLAST]),
        .irq_pending   (irq_pending),
        .parse_done    (parse_done),
        .desched_done  (desched_done),
        .stat          (stat),
        .parse_start   (parse_start),
        .desched_start (desched_start),
        .doorbell_req  (doorbell_req)
    );

    vpe_sched_fields #(.ID_W(ID_W)) u_fld (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .wr_cfg (cfg_from_word(bus_wdata)),
        .cfg    (cfg)
    );

    assign bus_rdata = addr_hit ? view_word(stat, cfg) : '0;
endmodule

// File: rtl/vpe_sched_chk.sv
module vpe_sched_chk (
    input logic clk,
    input logic rst,
    input logic wr_hit,
    input logic wr_valid_bit,
    input logic valid_q,
    input logic busy_q,
    input logic pend_last_q,
    input logic irq_pending,
    input logic parse_done,
    input logic desched_done,
    input logic parse_start,
    input logic desched_start,
    input logic doorbell_req
);
    AST_PARSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        parse_start |=> !parse_start); // R3
    AST_PARSE_STATE: assert property (@(posedge clk) disable iff (rst)
        parse_start |-> (valid_q && busy_q && pend_last_q)); // R3
    AST_PARSE_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (valid_q && busy_q && parse_done) |=> !busy_q); // R4
    AST_DESCHED_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        desched_start |=> !desched_start); // R5
    AST_DESCHED_STATE: assert property (@(posedge clk) disable iff (rst)
        desched_start |-> (!valid_q && busy_q && pend_last_q == $past(irq_pending))); // R5
    AST_DOORBELL_WITH_DESCHED: assert property (@(posedge clk) disable iff (rst)
        doorbell_req |-> (desched_start && !pend_last_q)); // R6
    AST_DESCHED_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!valid_q && busy_q && desched_done) |=> !busy_q); // R7
    AST_BUSY_BLOCKS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (busy_q && wr_hit && wr_valid_bit != valid_q) |=> ($stable(valid_q) && !parse_start && !desched_start)); // R8
endmodule

bind vpe_sched_reg vpe_sched_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_hit        (wr_hit),
    .wr_valid_bit  (bus_wdata[63]),
    .valid_q       (stat.valid),
    .busy_q        (stat.busy),
    .pend_last_q   (stat.pend_last),
    .irq_pending   (irq_pending),
    .parse_done    (parse_done),
    .desched_done  (desched_done),
    .parse_start   (parse_start),
    .desched_start (desched_start),
    .doorbell_req  (doorbell_req)
);

// File: tb/tb_vpe_sched_reg.sv
module tb_vpe_sched_reg;
    localparam int          ID_W = 12;
    localparam logic [15:0] OFF  = 16'h0078;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = OFF;
    logic [63:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [63:0] bus_rdata;
    logic        irq_pending = 1'b0;
    logic        parse_done = 1'b0;
    logic        desched_done = 1'b0;
    logic        parse_start, desched_start, doorbell_req;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    vpe_sched_reg #(.ADDR_W(16), .REG_OFFSET(OFF), .ID_W(ID_W)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .irq_pending(irq_pending),
        .parse_done(parse_done), .desched_done(desched_done),
        .parse_start(parse_start), .desched_start(desched_start),
        .doorbell_req(doorbell_req)
    );

    function automatic logic [63:0] wword(input logic v, db, pl, g0, g1, input logic [15:0] id);
        return {v, db, pl, 1'b0, g0, g1, 42'd0, id};
    endfunction

    function automatic logic [63:0] eword(input logic v, db, pl, busy, g0, g1, input logic [15:0] id);
        return {v, db & ~v, pl, busy, g0, g1, 42'd0, id & 16'h0FFF};
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(output logic [63:0] v);
        bus_addr = OFF;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [63:0] d, input logic [15:0] a);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = OFF;
    endtask

    task automatic pulse_done(input bit parse);
        @(negedge clk);
        if (parse) parse_done = 1'b1; else desched_done = 1'b1;
        @(negedge clk);
        parse_done = 1'b0; desched_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(r);
        chk("R1 reset readback", r, 64'd0);
        chk("R1 reset pulses", {61'd0, parse_start, desched_start, doorbell_req}, 64'd0);

        // R2: other address
        wr(wword(1, 1, 0, 1, 1, 16'h0123), 16'h0070);
        rd(r);
        chk("R2 foreign write ignored", r, 64'd0);
        bus_addr = 16'h0070; #1;
        chk("R2 foreign read zero", bus_rdata, 64'd0);
        bus_addr = OFF;

        // R10/R11 field sweep while unscheduled
        for (int k = 0; k < 16; k++) begin
            logic [15:0] id = 16'(k * 16'h1111 + 16'h0F0F * (k & 1));
            wr(wword(0, k[0], k[1], k[2], k[3], id), OFF);
            chk("R10 no pulse on field write", {61'd0, parse_start, desched_start, doorbell_req}, 64'd0);
            rd(r);
            chk("R10 R11 field write", r, eword(0, k[0], 0, 0, k[2], k[3], id));
        end

        // R3..R7 schedule/deschedule over all doorbell/pl/irq combos
        for (int c = 0; c < 8; c++) begin
            logic dbw = c[0], plw = c[1], irq = c[2];
            logic [15:0] id = 16'hF000 | 16'(c * 16'h0135);
            wr(wword(1, 1, 0, c[0], ~c[0], id), OFF);
            chk("R3 parse_start pulse", {63'd0, parse_start}, 64'd1);
            rd(r);
            chk("R3 R9 R11 scheduled busy", r, eword(1, 1, 1, 1, c[0], ~c[0], id));
            @(negedge clk);
            chk("R3 parse_start one cycle", {63'd0, parse_start}, 64'd0);
            pulse_done(1);
            rd(r);
            chk("R4 busy clears after parse", r, eword(1, 0, 1, 0, c[0], ~c[0], id));
            // R9: write keeping valid=1 is ignored
            wr(wword(1, 0, 0, ~c[0], c[0], 16'h0055), OFF);
            rd(r);
            chk("R9 write while valid ignored", r, eword(1, 0, 1, 0, c[0], ~c[0], id));
            irq_pending = irq;
            wr(wword(0, dbw, plw, c[0], ~c[0], id), OFF);
            irq_pending = 1'b0;
            chk("R5 R6 desched pulses", {62'd0, desched_start, doorbell_req},
                {62'd0, 1'b1, dbw & ~plw & ~irq});
            rd(r);
            chk("R5 descheduled state", r, eword(0, dbw, irq, 1, c[0], ~c[0], id));
            @(negedge clk);
            chk("R5 R6 pulses one cycle", {62'd0, desched_start, doorbell_req}, 64'd0);
            pulse_done(0);
            rd(r);
            chk("R7 busy clears after desched", r, eword(0, dbw, irq, 0, c[0], ~c[0], id));
        end

        // R4: parse_done ignored while idle
        pulse_done(1);
        rd(r);
        chk("R4 stray parse_done", r[60], 1'b0);

        // R8: toggle write while parse busy, and coincident with parse_done
        wr(wword(1, 0, 0, 1, 0, 16'h0007), OFF);
        wr(wword(0, 1, 0, 1, 0, 16'h0007), OFF);
        chk("R8 no desched while busy", {62'd0, desched_start, doorbell_req}, 64'd0);
        rd(r);
        chk("R8 valid kept while busy", r, eword(1, 0, 1, 1, 1, 0, 16'h0007));
        @(negedge clk);
        parse_done = 1'b1; bus_wdata = wword(0, 1, 0, 1, 0, 16'h0007); bus_wr = 1'b1;
        @(negedge clk);
        parse_done = 1'b0; bus_wr = 1'b0;
        chk("R8 coincident parse no pulse", {62'd0, desched_start, doorbell_req}, 64'd0);
        rd(r);
        chk("R8 coincident parse state", r, eword(1, 0, 1, 0, 1, 0, 16'h0007));
        wr(wword(0, 1, 0, 1, 0, 16'h0007), OFF);
        chk("R8 retry desched", {62'd0, desched_start, doorbell_req}, 64'd3);
        // coincident with desched_done
        @(negedge clk);
        desched_done = 1'b1; bus_wdata = wword(1, 0, 0, 1, 0, 16'h0007); bus_wr = 1'b1;
        @(negedge clk);
        desched_done = 1'b0; bus_wr = 1'b0;
        chk("R8 coincident desched no pulse", {63'd0, parse_start}, 64'd0);
        rd(r);
        chk("R8 coincident desched state", r, eword(0, 1, 0, 0, 1, 0, 16'h0007));
        wr(wword(1, 0, 0, 1, 0, 16'h0007), OFF);
        chk("R8 retry schedule", {63'd0, parse_start}, 64'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule